// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block produces all refresh traffic for one SDRAM device. In normal running it counts out a fixed refresh interval and owes the memory one AUTO REFRESH command each time the interval expires. It then asks a main arbiter for the command bus. Once granted, it pays the whole debt back to back at the row-cycle spacing, and then hands the bus back. Refreshes that cannot be issued because the grant is late accumulate up to a bounded debt.

On a pulse of its enter input the block first settles any refresh debt. It then issues the AUTO REFRESH encoding with the clock-enable pin driven low, which puts the memory into self refresh. Clock enable stays low for at least a minimum residency. An exit request is latched, and it is acted on only when the residency has elapsed and the system reports a stable clock. Clock enable is then raised and NOP commands are driven for the exit recovery time before the bus is released. All banks are assumed to be precharged before the arbiter grants the bus. The block has no streaming data path. The request/grant pair acts as the only back-pressure: the block holds its request until a grant arrives and never drives a command on its own before that.

Top module: `sdr_rfsh_seq`

## Requirements
- R1: While reset is asserted, `cke` is 1, `cmd` is NOP and `bus_req` is 0. The `cmd` field is {cs_n, ras_n, cas_n, we_n}: NOP = 4'b0111 and AUTO REFRESH = 4'b0001.
- R2: One refresh becomes owed every `REF_INTERVAL` clock cycles. With the grant held high, successive AUTO REFRESH commands appear exactly `REF_INTERVAL` cycles apart.
- R3: While refresh is owed, `bus_req` is 1. The first AUTO REFRESH is driven in the cycle after a grant is sampled. No AUTO REFRESH starts while waiting for a grant. `bus_req` drops once the debt is zero at the end of the row-cycle gap.
- R4: AUTO REFRESH commands issued during one bus ownership are exactly `T_RC` cycles apart, with NOP in between.
- R5: The debt saturates at `MAX_OWED`. Further interval expiries while the debt is full are lost.
- R6: A one-cycle enter pulse is remembered. After any owed refreshes, the block drives AUTO REFRESH with `cke` low in the same cycle, and NOP with `cke` low afterwards.
- R7: `cke` stays low for at least `T_RAS` cycles. An exit request made earlier is held, and `cke` rises exactly `T_RAS` cycles after entry when the clock is stable.
- R8: `cke` does not rise while `clk_stable` is 0. It rises in the cycle after `clk_stable` is seen high with an exit pending and residency met.
- R9: After `cke` rises, NOP is driven with `bus_req` high for exactly `T_XSR` cycles, and then `bus_req` drops.
- R10: An exit request outside self refresh, and an enter request during self refresh or its exit recovery, have no effect.
- R11: Self refresh clears the debt and restarts the interval. The first AUTO REFRESH after release appears `REF_INTERVAL`+2 cycles after `bus_req` drops (with grant high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_enter_req | input | 1 | Pulse or level asking to enter self refresh |
| sr_exit_req | input | 1 | Pulse or level asking to leave self refresh |
| clk_stable | input | 1 | System clock is stable; gates the exit |
| bus_gnt | input | 1 | Arbiter grant of the command bus |
| bus_req | output | 1 | Request for, and hold of, the command bus |
| cke | output | 1 | Clock enable to the memory |
| cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} command |

## Verification
The hardest situation to reach is a saturated debt released into a back-to-back burst. To get there, the stimulus withholds the grant for well over `MAX_OWED` intervals and then grants. It measures the first AUTO REFRESH against the grant cycle, the exact spacing, and the burst length, which must stay near `MAX_OWED` rather than the number of expired intervals. A self-refresh residency with the exit request already pending from the first cycle is also hard to reach. So is an exit blocked by an unstable clock. Both are reached by pulsing the exit input right after the falling edge of `cke`, and in a second entry by holding `clk_stable` low past the residency. Every cycle is also compared against a behavioural model.

// File: rtl/sdr_rfsh_pkg.sv
package sdr_rfsh_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP  = 4'b0111;
  localparam logic [3:0] CMD_AREF = 4'b0001;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAIT,
    PH_GAP,
    PH_SR,
    PH_XSR
  } phase_t;
endpackage

// File: rtl/rfsh_pacer.sv
// Free-running refresh interval counter; produces one tick per interval.
module rfsh_pacer #(
  parameter int INTERVAL = 1953
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == LAST);
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (at_end) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rfsh_debt.sv
// Saturating count of refreshes owed to the memory.
module rfsh_debt #(
  parameter int MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  input  logic take,
  output logic owed_any
);
  localparam int OW = $clog2(MAX + 1);
  localparam logic [OW-1:0] FULL = OW'(MAX);

  logic [OW-1:0] owed_q;

  assign owed_any = (owed_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     owed_q <= '0;
    else if (clear) owed_q <= '0;
    else begin
      case ({tick, take})
        2'b10: if (owed_q != FULL) owed_q <= owed_q + 1'b1;
        2'b01: owed_q <= owed_q - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rfsh_span.sv
// Restartable up-counter that flags when LEN cycles have passed since start.
module rfsh_span #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] c_q;

  assign done = (c_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          c_q <= LAST;
    else if (start)      c_q <= '0;
    else if (c_q != LAST) c_q <= c_q + 1'b1;
  end
endmodule

// File: rtl/sdr_rfsh_seq.sv
module sdr_rfsh_seq
  import sdr_rfsh_pkg::*;
#(
  parameter int REF_INTERVAL = 1953,
  parameter int T_RC         = 17,
  parameter int T_RAS        = 11,
  parameter int T_XSR        = 19,
  parameter int MAX_OWED     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sr_enter_req,
  input  logic       sr_exit_req,
  input  logic       clk_stable,
  input  logic       bus_gnt,
  output logic       bus_req,
  output logic       cke,
  output logic [3:0] cmd
);
  phase_t     ph_q, ph_d;
  logic [3:0] cmd_q, cmd_d;
  logic       cke_q, cke_d;
  logic       enter_pend_q, exit_pend_q;
  logic       enter_seen, exit_seen, sr_zone, decide;
  logic       tick, owed_any, take;
  logic       gap_start, gap_done, res_start, res_done, xsr_start, xsr_done;

  assign sr_zone    = (ph_q == PH_SR) || (ph_q == PH_XSR);
  assign enter_seen = enter_pend_q | sr_enter_req;
  assign exit_seen  = exit_pend_q | sr_exit_req;
  assign decide     = ((ph_q == PH_WAIT) && bus_gnt) || ((ph_q == PH_GAP) && gap_done);

  rfsh_pacer #(.INTERVAL(REF_INTERVAL)) u_pacer (
    .clk(clk), .rst_n(rst_n), .run(!sr_zone), .tick(tick)
  );

  rfsh_debt #(.MAX(MAX_OWED)) u_debt (
    .clk(clk), .rst_n(rst_n), .clear(sr_zone), .tick(tick), .take(take),
    .owed_any(owed_any)
  );

  rfsh_span #(.LEN(T_RC)) u_gap (
    .clk(clk), .rst_n(rst_n), .start(gap_start), .done(gap_done)
  );

  rfsh_span #(.LEN(T_RAS)) u_res (
    .clk(clk), .rst_n(rst_n), .start(res_start), .done(res_done)
  );

  rfsh_span #(.LEN(T_XSR)) u_xsr (
    .clk(clk), .rst_n(rst_n), .start(xsr_start), .done(xsr_done)
  );

  always_comb begin
    ph_d      = ph_q;
    cmd_d     = CMD_NOP;
    cke_d     = cke_q;
    take      = 1'b0;
    gap_start = 1'b0;
    res_start = 1'b0;
    xsr_start = 1'b0;
    case (ph_q)
      PH_IDLE: if (owed_any || enter_seen) ph_d = PH_WAIT;
      PH_SR: begin
        if (res_done && exit_seen && clk_stable) begin
          ph_d      = PH_XSR;
          cke_d     = 1'b1;
          xsr_start = 1'b1;
        end
      end
      PH_XSR: if (xsr_done) ph_d = PH_IDLE;
      default: ;
    endcase
    if (decide) begin
      if (owed_any) begin
        cmd_d     = CMD_AREF;
        take      = 1'b1;
        gap_start = 1'b1;
        ph_d      = PH_GAP;
      end else if (enter_seen) begin
        cmd_d     = CMD_AREF;
        cke_d     = 1'b0;
        res_start = 1'b1;
        ph_d      = PH_SR;
      end else begin
        ph_d = PH_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q         <= PH_IDLE;
      cmd_q        <= CMD_NOP;
      cke_q        <= 1'b1;
      enter_pend_q <= 1'b0;
      exit_pend_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cmd_q <= cmd_d;
      cke_q <= cke_d;
      if (res_start)                      enter_pend_q <= 1'b0;
      else if (sr_enter_req && !sr_zone)  enter_pend_q <= 1'b1;
      if (xsr_start)                          exit_pend_q <= 1'b0;
      else if (sr_exit_req && ph_q == PH_SR)  exit_pend_q <= 1'b1;
    end
  end

  assign bus_req = (ph_q != PH_IDLE);
  assign cmd     = cmd_q;
  assign cke     = cke_q;
endmodule

// File: rtl/sdr_rfsh_chk.sv
module sdr_rfsh_chk
  import sdr_rfsh_pkg::*;
#(
  parameter int T_RC  = 17,
  parameter int T_RAS = 11,
  parameter int T_XSR = 19
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_stable,
  input logic       bus_req,
  input logic       cke,
  input logic [3:0] cmd
);
  int gap_c, low_c, hi_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_c <= T_RC;
      low_c <= 0;
      hi_c  <= T_XSR;
    end else begin
      if (cmd == CMD_AREF) gap_c <= 1;
      else if (gap_c < T_RC) gap_c <= gap_c + 1;
      if (!cke) begin
        if (low_c < T_RAS) low_c <= low_c + 1;
        hi_c <= 0;
      end else begin
        low_c <= 0;
        if (hi_c < T_XSR) hi_c <= hi_c + 1;
      end
    end
  end

  AST_AREF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_AREF) |-> (gap_c >= T_RC)); // R4
  AST_AREF_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_AREF) |-> bus_req); // R3
  AST_SR_ENTRY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (cmd == CMD_AREF)); // R6
  AST_SR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !$fell(cke)) |-> (cmd == CMD_NOP && bus_req)); // R6
  AST_MIN_RESIDENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (low_c >= T_RAS)); // R7
  AST_EXIT_STABLE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(clk_stable)); // R8
  AST_EXIT_NOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && hi_c < T_XSR) |-> (cmd == CMD_NOP && bus_req)); // R9
endmodule

bind sdr_rfsh_seq sdr_rfsh_chk #(
  .T_RC(T_RC), .T_RAS(T_RAS), .T_XSR(T_XSR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable),
  .bus_req(bus_req), .cke(cke), .cmd(cmd)
);

// File: tb/tb_sdr_rfsh_seq.sv
module tb_sdr_rfsh_seq;
  import sdr_rfsh_pkg::*;

  localparam int RI   = 30;
  localparam int TRC  = 4;
  localparam int TRAS = 10;
  localparam int TXSR = 3;
  localparam int MAXO = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sr_enter_req = 1'b0, sr_exit_req = 1'b0, clk_stable = 1'b1, bus_gnt = 1'b1;
  logic bus_req, cke;
  logic [3:0] cmd;

  int nchk = 0, nbad = 0, cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sdr_rfsh_seq #(
    .REF_INTERVAL(RI), .T_RC(TRC), .T_RAS(TRAS), .T_XSR(TXSR), .MAX_OWED(MAXO)
  ) dut (
    .clk(clk), .rst_n(rst_n), .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req),
    .clk_stable(clk_stable), .bus_gnt(bus_gnt), .bus_req(bus_req), .cke(cke), .cmd(cmd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference: 0 idle, 1 waiting, 2 gap, 3 self refresh, 4 exit recovery
  int ms, icnt, owed, g, res, x;
  bit epend, xpend, m_cke;
  logic [3:0] m_cmd;

  always @(posedge clk) begin
    bit zone, en_s, ex_s, tk, took, dec, entered, left, ncke;
    int nms;
    logic [3:0] ncmd;
    cyc++;
    if (!rst_n) begin
      ms = 0; icnt = 0; owed = 0; g = 0; res = 0; x = 0;
      epend = 0; xpend = 0; m_cke = 1; m_cmd = CMD_NOP;
    end else begin
      zone = (ms >= 3);
      en_s = epend || sr_enter_req;
      ex_s = xpend || sr_exit_req;
      tk = !zone && (icnt == RI - 1);
      took = 0; dec = 0; entered = 0; left = 0;
      nms = ms; ncmd = CMD_NOP; ncke = m_cke;
      case (ms)
        0: if (owed > 0 || en_s) nms = 1;
        1: if (bus_gnt) dec = 1;
        2: if (g == TRC - 1) dec = 1; else g++;
        3: if (res < TRAS - 1) res++;
           else if (ex_s && clk_stable) begin nms = 4; ncke = 1; x = 0; left = 1; end
        4: if (x == TXSR - 1) nms = 0; else x++;
        default: ;
      endcase
      if (dec) begin
        if (owed > 0) begin ncmd = CMD_AREF; took = 1; g = 0; nms = 2; end
        else if (en_s) begin ncmd = CMD_AREF; ncke = 0; res = 0; nms = 3; entered = 1; end
        else nms = 0;
      end
      icnt = zone ? 0 : ((icnt == RI - 1) ? 0 : icnt + 1);
      if (zone) owed = 0;
      else begin
        owed = owed + (tk ? 1 : 0) - (took ? 1 : 0);
        if (owed > MAXO) owed = MAXO;
      end
      if (entered) epend = 0; else if (sr_enter_req && !zone) epend = 1;
      if (left) xpend = 0; else if (sr_exit_req && ms == 3) xpend = 1;
      ms = nms; m_cmd = ncmd; m_cke = ncke;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(cmd == m_cmd, "R2 model cmd", int'(cmd), int'(m_cmd));
      chk(cke == m_cke, "R6 model cke", int'(cke), int'(m_cke));
      chk(bus_req == (ms != 0), "R3 model bus_req", int'(bus_req), int'(ms != 0));
    end
  end

  task automatic wait_ar();
    @(negedge clk);
    while (cmd != CMD_AREF) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int prev, first, g0, run, stray, t_low, t_hi, t_rel, n, bad_nop;
    bit saw, lowseen;
    repeat (5) @(negedge clk);
    chk(cke == 1'b1, "R1 cke in reset", int'(cke), 1);
    chk(cmd == CMD_NOP, "R1 cmd in reset", int'(cmd), int'(CMD_NOP));
    chk(bus_req == 1'b0, "R1 bus_req in reset", int'(bus_req), 0);
    rst_n = 1'b1;

    // R2: paced refresh with immediate grant
    prev = -1;
    for (int i = 0; i < 5; i++) begin
      wait_ar();
      if (prev >= 0) chk(cyc - prev == RI, "R2 refresh spacing", cyc - prev, RI);
      prev = cyc;
    end

    // R3/R5: withhold grant, debt saturates
    bus_gnt = 1'b0;
    saw = 0;
    repeat (400) begin
      @(negedge clk);
      if (cmd == CMD_AREF && bus_req && ms == 1) saw = 1;
    end
    chk(bus_req == 1'b1, "R3 request while owed", int'(bus_req), 1);
    chk(saw == 0, "R3 no refresh before grant", int'(saw), 0);
    g0 = cyc;
    bus_gnt = 1'b1;
    wait_ar();
    first = cyc;
    chk(first == g0 + 1, "R3 refresh cycle after grant", first, g0 + 1);
    run = 1; stray = 0;
    for (int k = 0; k < 20; k++) begin
      bit hit;
      for (int j = 0; j < TRC - 1; j++) begin
        @(negedge clk);
        if (cmd == CMD_AREF) stray++;
      end
      @(negedge clk);
      hit = (cmd == CMD_AREF);
      if (!hit) break;
      run++;
    end
    chk(stray == 0, "R4 nothing between back-to-back refreshes", stray, 0);
    chk(run >= MAXO && run <= MAXO + 2, "R5 burst bounded by saturated debt", run, MAXO);
    chk(bus_req == 1'b0, "R3 bus released after burst", int'(bus_req), 0);

    // R10: exit request outside self refresh
    sr_exit_req = 1'b1;
    @(negedge clk);
    sr_exit_req = 1'b0;
    lowseen = 0;
    repeat (50) begin
      @(negedge clk);
      if (!cke) lowseen = 1;
    end
    chk(lowseen == 0, "R10 stray exit ignored", int'(lowseen), 0);

    // R6/R7/R9: entry, early exit request, recovery
    sr_enter_req = 1'b1;
    @(negedge clk);
    sr_enter_req = 1'b0;
    while (cke) @(negedge clk);
    t_low = cyc;
    chk(cmd == CMD_AREF, "R6 entry command with cke low", int'(cmd), int'(CMD_AREF));
    sr_exit_req = 1'b1;
    sr_enter_req = 1'b1;
    @(negedge clk);
    sr_exit_req = 1'b0;
    sr_enter_req = 1'b0;
    chk(cmd == CMD_NOP && !cke, "R6 NOP while in self refresh", int'(cmd), int'(CMD_NOP));
    while (!cke) @(negedge clk);
    t_hi = cyc;
    chk(t_hi - t_low == TRAS, "R7 residency before exit", t_hi - t_low, TRAS);
    n = 0; bad_nop = 0;
    while (bus_req) begin
      if (cmd != CMD_NOP) bad_nop++;
      n++;
      @(negedge clk);
    end
    t_rel = cyc;
    chk(n == TXSR, "R9 exit recovery length", n, TXSR);
    chk(bad_nop == 0, "R9 NOP during recovery", bad_nop, 0);

    // R11 and R10 (enter during self refresh ignored)
    wait_ar();
    chk(cyc - t_rel == RI + 2, "R11 interval restarts after release", cyc - t_rel, RI + 2);
    chk(cke == 1'b1, "R10 enter during self refresh ignored", int'(cke), 1);

    // R8: exit blocked by unstable clock
    sr_enter_req = 1'b1;
    @(negedge clk);
    sr_enter_req = 1'b0;
    while (cke) @(negedge clk);
    clk_stable = 1'b0;
    sr_exit_req = 1'b1;
    @(negedge clk);
    sr_exit_req = 1'b0;
    repeat (TRAS + 20) @(negedge clk);
    chk(cke == 1'b0, "R8 no exit without stable clock", int'(cke), 0);
    clk_stable = 1'b1;
    @(negedge clk);
    chk(cke == 1'b1, "R8 exit once clock stable", int'(cke), 1);
    while (bus_req) @(negedge clk);
    repeat (5) @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule